// File: doc/BRIEF.md
# Segmented Word-Line Pulse Sequencer

This block drives the row inputs of a compute-in-memory array. It takes one multi-bit activation per row, cuts each activation into a high, a middle and a low slice (2, 3 and 3 bits by default), and plays the slices out as three phases. In each phase every row's word-line enable is held high for as many unit ticks as that row's slice value. All rows run in lock step, so their cell currents add on each column bitline.

Alongside the word lines the block sequences the analog side of the column. Before the high phase it clears the integration capacitor. At the end of the high phase it strobes the converter. The middle and low phases keep the capacitor voltage and route the bitline current through a mirror branch scaled down by two to the power of the width of the phase being entered. A final converter strobe and a one-cycle done flag close the operation.

A caller presents all row activations on one flat bus and pulses `start`. The activations are captured on that edge. Every later start is ignored until the block returns to idle.

Top module: `seg_wl_sequencer`

## Requirements
- R1: During and directly after reset, every output is low: `busy`, `done`, `cap_reset`, `adc_sample`, `hold`, `wl_en` and `branch_sel` (which reads 0).
- R2: Row r's activation is `act_in[r*8 +: 8]`. Bits [7:6] form the high slice, [5:3] the middle slice and [2:0] the low slice. The phases run high, then middle, then low.
- R3: Within a phase, a row's `wl_en` bit is high on the first v ticks of the phase and low on the rest, where v is that row's slice value.
- R4: A slice of zero keeps the row's enable low for the whole phase. An all-ones slice keeps it high for every tick of the phase.
- R5: Phase length does not depend on the data: 2^w − 1 cycles for a slice of width w. With the defaults that is 3, 7 and 7 cycles.
- R6: Every row's pulse in a phase starts on the phase's first tick, so all rows overlap.
- R7: The cycle after a start is taken has `cap_reset` high with no word line active. The high phase follows. After it comes one cycle with `adc_sample` high. Throughout this part `hold` is low and `branch_sel` is 0 (unscaled).
- R8: The middle and low phases never raise `cap_reset`. They hold `hold` high and set `branch_sel` to 1 (the middle branch, scaled by 1/2^3) and to 2 (the low branch, scaled by 1/2^3), respectively.
- R9: After the low phase there is one more cycle with `adc_sample` high (`hold` high, `branch_sel` 2), then one cycle with `done` high. The block is then idle. `busy` is high from the reset cycle through the done cycle: 21 cycles with the defaults.
- R10: A start while `busy` is high changes neither the captured activations nor the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an operation; taken only when idle |
| act_in | input | ROWS*8 | Row activations, row r at bits r*8 +: 8 |
| busy | output | 1 | Operation in progress |
| wl_en | output | ROWS | Word-line enable, one bit per row |
| cap_reset | output | 1 | Clear the integration capacitor |
| adc_sample | output | 1 | Converter sample strobe |
| hold | output | 1 | Keep the capacitor voltage across phases |
| branch_sel | output | 2 | Mirror branch: 0 unscaled, 1 middle scale, 2 low scale |
| done | output | 1 | One-cycle end-of-operation flag |

## Verification
The bench builds the block with ROWS = 3 and the default 2/3/3 slicing. Three rows are enough to put an all-zero, an all-ones and a mixed activation side by side in a single operation, so the zero-length pulse, the full-phase pulse and the partial pulse are all checked against the same phase boundaries. The default slicing brings in both a short 3-tick phase and two 7-tick phases. A start issued mid-operation with inverted data, and a start issued in the very cycle the block turns idle, cover the capture and re-arm edges.

// File: rtl/seg_wl_sequencer.sv
module seg_wl_sequencer #(
  parameter int ROWS  = 4,
  parameter int W_HI  = 2,
  parameter int W_MID = 3,
  parameter int W_LO  = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic [ROWS*(W_HI+W_MID+W_LO)-1:0] act_in,
  output logic                    busy,
  output logic [ROWS-1:0]         wl_en,
  output logic                    cap_reset,
  output logic                    adc_sample,
  output logic                    hold,
  output logic [1:0]              branch_sel,
  output logic                    done
);
  localparam int DW = W_HI + W_MID + W_LO;
  localparam int TW = (W_HI > W_MID) ? ((W_HI > W_LO) ? W_HI : W_LO)
                                     : ((W_MID > W_LO) ? W_MID : W_LO);
  localparam logic [TW-1:0] LEN_HI  = TW'((1 << W_HI) - 1);
  localparam logic [TW-1:0] LEN_MID = TW'((1 << W_MID) - 1);
  localparam logic [TW-1:0] LEN_LO  = TW'((1 << W_LO) - 1);

  typedef enum logic [2:0] {S_IDLE, S_RST, S_PH, S_SMP, S_FSMP, S_DONE} st_t;

  st_t                  st;
  logic [1:0]           ph;
  logic [TW-1:0]        tick;
  logic [ROWS*DW-1:0]   act_q;
  logic [TW-1:0]        ph_len;

  assign ph_len = (ph == 2'd0) ? LEN_HI : (ph == 2'd1) ? LEN_MID : LEN_LO;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      ph    <= '0;
      tick  <= '0;
      act_q <= '0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          act_q <= act_in;
          st    <= S_RST;
        end
        S_RST: begin
          st   <= S_PH;
          ph   <= 2'd0;
          tick <= '0;
        end
        S_PH: begin
          if (tick == ph_len - 1'b1) begin
            tick <= '0;
            case (ph)
              2'd0:    st <= S_SMP;
              2'd1:    ph <= 2'd2;
              default: st <= S_FSMP;
            endcase
          end else begin
            tick <= tick + 1'b1;
          end
        end
        S_SMP: begin
          st <= S_PH;
          ph <= 2'd1;
        end
        S_FSMP:  st <= S_DONE;
        default: st <= S_IDLE;
      endcase
    end
  end

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    logic [DW-1:0] a;
    logic [TW-1:0] sl;
    assign a  = act_q[r*DW +: DW];
    assign sl = (ph == 2'd0) ? TW'(a[DW-1 -: W_HI]) :
                (ph == 2'd1) ? TW'(a[W_LO +: W_MID]) : TW'(a[0 +: W_LO]);
    assign wl_en[r] = (st == S_PH) && (tick < sl);
  end

  assign busy       = (st != S_IDLE);
  assign cap_reset  = (st == S_RST);
  assign adc_sample = (st == S_SMP) || (st == S_FSMP);
  assign hold       = ((st == S_PH) && (ph != 2'd0)) || (st == S_FSMP);
  assign branch_sel = ((st == S_PH) && (ph == 2'd1)) ? 2'd1 :
                      (((st == S_PH) && (ph == 2'd2)) || (st == S_FSMP)) ? 2'd2 : 2'd0;
  assign done       = (st == S_DONE);
endmodule

// File: rtl/seg_wl_sequencer_chk.sv
module seg_wl_sequencer_chk #(
  parameter int ROWS = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            start,
  input logic            busy,
  input logic [ROWS-1:0] wl_en,
  input logic            cap_reset,
  input logic            adc_sample,
  input logic            hold,
  input logic [1:0]      branch_sel,
  input logic            done
);
  // R7
  reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_reset |-> (wl_en == '0) && !hold && !adc_sample && (branch_sel == 2'd0));
  // R7
  reset_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_reset |=> !cap_reset && busy);
  // R8
  hold_no_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold |-> !cap_reset);
  // R8
  scaled_needs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (branch_sel != 2'd0) |-> hold);
  // R3
  wl_in_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wl_en != '0) |-> busy && !adc_sample && !done);
  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && !busy);
  // R9
  done_after_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(adc_sample) && $past(hold));
  // R10
  start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done && start) |=> busy && !cap_reset);
endmodule

bind seg_wl_sequencer seg_wl_sequencer_chk #(.ROWS(ROWS)) chk_i (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .wl_en(wl_en),
  .cap_reset(cap_reset), .adc_sample(adc_sample), .hold(hold),
  .branch_sel(branch_sel), .done(done)
);

// File: tb/seg_wl_sequencer_test.sv
`timescale 1ns/1ps
module seg_wl_sequencer_test;
  localparam int ROWS = 3;
  localparam int DW = 8;
  localparam int L0 = 3, L1 = 7, L2 = 7;

  logic clk = 0, rst_n = 0, start = 0;
  logic [ROWS*DW-1:0] act_in = '0;
  logic busy, cap_reset, adc_sample, hold, done;
  logic [ROWS-1:0] wl_en;
  logic [1:0] branch_sel;

  seg_wl_sequencer #(.ROWS(ROWS)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .act_in(act_in), .busy(busy),
    .wl_en(wl_en), .cap_reset(cap_reset), .adc_sample(adc_sample),
    .hold(hold), .branch_sel(branch_sel), .done(done)
  );

  always #5 clk = ~clk;

  typedef struct {
    logic [ROWS-1:0] wl;
    logic cap, smp, hld, bsy, dn;
    logic [1:0] br;
    string req;
  } item_t;

  item_t q[$];
  int checks = 0, errors = 0;
  bit finished = 0;
  string idle_req = "R1";

  function automatic item_t exp_at(int c, logic [ROWS*DW-1:0] v);
    item_t e;
    int t, sv;
    e.wl = '0; e.cap = 0; e.smp = 0; e.hld = 0; e.bsy = 1; e.dn = 0; e.br = 2'd0;
    e.req = "R7";
    if (c == 0) e.cap = 1;
    else if (c <= L0) begin
      t = c - 1; e.req = "R2/R3/R4/R5/R6";
      for (int r = 0; r < ROWS; r++) begin
        sv = int'(v[r*DW+6 +: 2]); e.wl[r] = (t < sv);
      end
    end else if (c == L0 + 1) e.smp = 1;
    else if (c <= L0 + 1 + L1) begin
      t = c - L0 - 2; e.hld = 1; e.br = 2'd1; e.req = "R2/R3/R4/R5/R6/R8";
      for (int r = 0; r < ROWS; r++) begin
        sv = int'(v[r*DW+3 +: 3]); e.wl[r] = (t < sv);
      end
    end else if (c <= L0 + 1 + L1 + L2) begin
      t = c - L0 - L1 - 2; e.hld = 1; e.br = 2'd2; e.req = "R2/R3/R4/R5/R6/R8";
      for (int r = 0; r < ROWS; r++) begin
        sv = int'(v[r*DW +: 3]); e.wl[r] = (t < sv);
      end
    end else if (c == L0 + L1 + L2 + 2) begin
      e.smp = 1; e.hld = 1; e.br = 2'd2; e.req = "R9";
    end else begin
      e.dn = 1; e.req = "R9";
    end
    return e;
  endfunction

  task automatic cmp(string req, string what, logic [7:0] act, logic [7:0] ex);
    checks++;
    if (act !== ex) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, ex, $time);
    end
  endtask

  task automatic check_item(item_t e);
    cmp(e.req, "wl_en", 8'(wl_en), 8'(e.wl));
    cmp(e.req, "cap_reset", 8'(cap_reset), 8'(e.cap));
    cmp(e.req, "adc_sample", 8'(adc_sample), 8'(e.smp));
    cmp(e.req, "hold", 8'(hold), 8'(e.hld));
    cmp(e.req, "branch_sel", 8'(branch_sel), 8'(e.br));
    cmp(e.req, "busy", 8'(busy), 8'(e.bsy));
    cmp(e.req, "done", 8'(done), 8'(e.dn));
  endtask

  task automatic check_idle(string req);
    item_t e;
    e.wl = '0; e.cap = 0; e.smp = 0; e.hld = 0; e.bsy = 0; e.dn = 0; e.br = 2'd0;
    e.req = req;
    check_item(e);
  endtask

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (q.size() > 0) check_item(q.pop_front());
      else check_idle(idle_req);
    end
  end

  task automatic run(logic [ROWS*DW-1:0] v, bit poke, bit rearm);
    @(posedge clk); #1 start = 1; act_in = v;
    @(posedge clk); #1 start = 0;
    for (int c = 0; c < L0 + L1 + L2 + 4; c++) q.push_back(exp_at(c, v));
    if (poke) begin
      // R10: a start with other data during the middle phase must be ignored
      repeat (6) @(posedge clk);
      #1 start = 1; act_in = ~v;
      @(posedge clk); #1 start = 0;
    end
    while (q.size() > 0) @(posedge clk);
    if (rearm) begin
      // R9/R10: start held through the done cycle is taken only once idle
      #1 start = 1;
      @(posedge clk); #1 start = 0;
      for (int c = 0; c < L0 + L1 + L2 + 4; c++) q.push_back(exp_at(c, act_in));
      while (q.size() > 0) @(posedge clk);
    end
    repeat (2) @(posedge clk);
  endtask

  initial begin
    // R1: outputs quiet while in reset
    repeat (3) @(posedge clk);
    @(negedge clk) check_idle("R1");
    #1 rst_n = 1;
    repeat (3) @(posedge clk);
    // R4: all-ones, all-zero and mixed rows side by side
    run({8'hA5, 8'h00, 8'hFF}, 0, 0);
    // R2: distinct slices per phase
    idle_req = "R10";
    run({8'h7F, 8'hB6, 8'h49}, 1, 0);
    idle_req = "R9";
    run({8'h12, 8'hC8, 8'h3B}, 0, 1);
    run({8'h80, 8'h40, 8'h01}, 0, 0);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule